// File: doc/BRIEF.md
# Byte Read-Modify-Write Adapter

This block puts a byte-granular client port in front of a backing store that can only move whole words. The store has no byte enables and is indexed by word number, so two neighbouring words differ by one in the index, not by the word size. The client presents a byte address, a direction flag and, for stores, one data byte. The adapter splits the byte address into a word index and a byte lane, then runs a short sequence against the store.

A load fetches the containing word and returns the selected byte. A store fetches the containing word, replaces only the selected lane, and writes the whole word back, so the other bytes of that word keep their values. The word size is a parameter of 2 or 4 bytes. While a sequence is running the adapter refuses new requests, so the client waits on the ready flag between operations.

Top module: `byte_rmw_adapter`

## Requirements
- R1: After reset `req_ready` is 1, and `busy`, `rsp_valid` and `mem_req` are 0.
- R2: The word index is the byte address shifted right by log2(BYTES_PER_WORD). The lane is the dropped low address bits, and lane 0 is bits [7:0] of the word.
- R3: A load accepted at clock edge E issues one store read (`mem_req`=1, `mem_we`=0) in the cycle after E. `rsp_valid` is high for exactly the following cycle, with `rsp_data` = (word >> 8*lane) & 8'hFF.
- R4: A store accepted at edge E reads the word in the cycle after E. Two cycles later it writes the same index once, with only the addressed lane replaced by the new byte. All other lanes are equal to the word that was read.
- R5: `busy` is high and `req_ready` is low from acceptance for 2 cycles on a load and 4 cycles on a store. `busy` is the inverse of `req_ready`.
- R6: `rsp_valid` is never raised for a store. `rsp_data` is 0 whenever `rsp_valid` is low.
- R7: A request held on `req_valid` while `busy` is high is ignored. It causes no access to the store, and a later load of its address returns the earlier contents.
- R8: `mem_req` is high only in the read cycle and in the write cycle of a sequence, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Adapter can accept a request this cycle |
| req_write | input | 1 | 1 = byte store, 0 = byte load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to store |
| busy | output | 1 | A sequence is in progress |
| rsp_valid | output | 1 | One-cycle strobe carrying load data |
| rsp_data | output | 8 | Loaded byte |
| mem_req | output | 1 | Store access strobe |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_idx | output | ADDR_W-log2(BYTES_PER_WORD) | Word index |
| mem_wdata | output | 8*BYTES_PER_WORD | Word to write |
| mem_rdata | input | 8*BYTES_PER_WORD | Read word, valid the cycle after a read strobe |

## Verification
The checker watches the protocol-level rules on every cycle. Every write is preceded two cycles earlier by a read of the same index. A written word differs from the word just read in at most one lane. The response strobe lasts one cycle and always follows a read. `busy` and `req_ready` never overlap, and no store access happens while idle. Only the bench scenarios can show that the right lane is chosen for each address and that loaded bytes hold the values stored earlier. They also show that the neighbouring bytes survive a store and that a request held off during a sequence leaves no trace. The bench covers this with a full sweep of every byte address, for stores and then for loads.

// File: rtl/byte_rmw_pkg.sv
package byte_rmw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_MERGE = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } rmw_state_e;
endpackage

// File: rtl/rmw_addr_split.sv
module rmw_addr_split #(
    parameter int ADDR_W         = 6,
    parameter int BYTES_PER_WORD = 4
) (
    input  logic [ADDR_W-1:0]                        byte_addr,
    output logic [ADDR_W-$clog2(BYTES_PER_WORD)-1:0] word_idx,
    output logic [$clog2(BYTES_PER_WORD)-1:0]        lane
);
    localparam int LANE_W = $clog2(BYTES_PER_WORD);

    // Low bits pick the byte inside the word; the rest index the word.
    assign lane     = byte_addr[LANE_W-1:0];
    assign word_idx = byte_addr[ADDR_W-1:LANE_W];
endmodule

// File: rtl/rmw_lane_extract.sv
module rmw_lane_extract #(
    parameter int BYTES_PER_WORD = 4
) (
    input  logic [8*BYTES_PER_WORD-1:0]       word_i,
    input  logic [$clog2(BYTES_PER_WORD)-1:0] lane,
    output logic [7:0]                        byte_o
);
    logic [7:0] lanes [BYTES_PER_WORD];

    for (genvar l = 0; l < BYTES_PER_WORD; l++) begin : g_lane
        assign lanes[l] = word_i[8*l +: 8];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge #(
    parameter int BYTES_PER_WORD = 4
) (
    input  logic [8*BYTES_PER_WORD-1:0]       word_i,
    input  logic [$clog2(BYTES_PER_WORD)-1:0] lane,
    input  logic [7:0]                        byte_i,
    output logic [8*BYTES_PER_WORD-1:0]       word_o
);
    // Each lane either keeps the old byte or takes the new one.
    for (genvar l = 0; l < BYTES_PER_WORD; l++) begin : g_lane
        assign word_o[8*l +: 8] = (lane == l) ? byte_i : word_i[8*l +: 8];
    end
endmodule

// File: rtl/byte_rmw_adapter.sv
module byte_rmw_adapter
    import byte_rmw_pkg::*;
#(
    parameter int ADDR_W         = 6,
    parameter int BYTES_PER_WORD = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      req_valid,
    output logic                                      req_ready,
    input  logic                                      req_write,
    input  logic [ADDR_W-1:0]                         req_addr,
    input  logic [7:0]                                req_wdata,
    output logic                                      busy,
    output logic                                      rsp_valid,
    output logic [7:0]                                rsp_data,
    output logic                                      mem_req,
    output logic                                      mem_we,
    output logic [ADDR_W-$clog2(BYTES_PER_WORD)-1:0]  mem_idx,
    output logic [8*BYTES_PER_WORD-1:0]               mem_wdata,
    input  logic [8*BYTES_PER_WORD-1:0]               mem_rdata
);
    localparam int LANE_W = $clog2(BYTES_PER_WORD);
    localparam int IDX_W  = ADDR_W - LANE_W;
    localparam int WORD_W = 8 * BYTES_PER_WORD;

    initial begin
        if (BYTES_PER_WORD != 2 && BYTES_PER_WORD != 4)
            $error("BYTES_PER_WORD must be 2 or 4");
    end

    typedef struct packed {
        rmw_state_e        st;
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [LANE_W-1:0] lane;
        logic [7:0]        wbyte;
        logic [WORD_W-1:0] word;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:    ST_IDLE,
        wr:    1'b0,
        idx:   '0,
        lane:  '0,
        wbyte: '0,
        word:  '0
    };

    regs_t regs_d, regs_q;

    logic [IDX_W-1:0]  req_idx;
    logic [LANE_W-1:0] req_lane;
    logic [7:0]        rd_byte;
    logic [WORD_W-1:0] merged_word;

    rmw_addr_split #(
        .ADDR_W        (ADDR_W),
        .BYTES_PER_WORD(BYTES_PER_WORD)
    ) u_split (
        .byte_addr(req_addr),
        .word_idx (req_idx),
        .lane     (req_lane)
    );

    rmw_lane_extract #(
        .BYTES_PER_WORD(BYTES_PER_WORD)
    ) u_extract (
        .word_i(mem_rdata),
        .lane  (regs_q.lane),
        .byte_o(rd_byte)
    );

    rmw_lane_merge #(
        .BYTES_PER_WORD(BYTES_PER_WORD)
    ) u_merge (
        .word_i(mem_rdata),
        .lane  (regs_q.lane),
        .byte_i(regs_q.wbyte),
        .word_o(merged_word)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.st    = ST_READ;
                    regs_d.wr    = req_write;
                    regs_d.idx   = req_idx;
                    regs_d.lane  = req_lane;
                    regs_d.wbyte = req_wdata;
                end
            end
            ST_READ:  regs_d.st = regs_q.wr ? ST_MERGE : ST_DONE;
            ST_MERGE: begin
                regs_d.word = merged_word;
                regs_d.st   = ST_WRITE;
            end
            ST_WRITE: regs_d.st = ST_DONE;
            ST_DONE:  regs_d.st = ST_IDLE;
            default:  regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign req_ready = (regs_q.st == ST_IDLE);
    assign busy      = !req_ready;
    assign mem_req   = (regs_q.st == ST_READ) || (regs_q.st == ST_WRITE);
    assign mem_we    = (regs_q.st == ST_WRITE);
    assign mem_idx   = regs_q.idx;
    assign mem_wdata = regs_q.word;
    assign rsp_valid = (regs_q.st == ST_DONE) && !regs_q.wr;
    assign rsp_data  = rsp_valid ? rd_byte : 8'h00;
endmodule

// File: rtl/byte_rmw_adapter_chk.sv
module byte_rmw_adapter_chk #(
    parameter int ADDR_W         = 6,
    parameter int BYTES_PER_WORD = 4
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     req_valid,
    input logic                                     req_ready,
    input logic                                     busy,
    input logic                                     rsp_valid,
    input logic [7:0]                               rsp_data,
    input logic                                     mem_req,
    input logic                                     mem_we,
    input logic [ADDR_W-$clog2(BYTES_PER_WORD)-1:0] mem_idx,
    input logic [8*BYTES_PER_WORD-1:0]              mem_wdata,
    input logic [8*BYTES_PER_WORD-1:0]              mem_rdata
);
    logic [8*BYTES_PER_WORD-1:0] rdata_prev;
    logic [BYTES_PER_WORD-1:0]   lane_diff;

    always_ff @(posedge clk) rdata_prev <= mem_rdata;

    for (genvar l = 0; l < BYTES_PER_WORD; l++) begin : g_diff
        assign lane_diff[l] = |(mem_wdata[8*l +: 8] ^ rdata_prev[8*l +: 8]);
    end

    p_ready_busy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    p_write_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));

    p_write_same_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_idx == $past(mem_idx, 2)));

    p_single_lane_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(lane_diff) <= 1));

    p_rsp_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_req && !mem_we));

    p_rsp_data_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_data == 8'h00));

    p_no_access_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
endmodule

bind byte_rmw_adapter byte_rmw_adapter_chk #(
    .ADDR_W        (ADDR_W),
    .BYTES_PER_WORD(BYTES_PER_WORD)
) u_chk (.*);

// File: tb/byte_rmw_adapter_test.sv
module byte_rmw_adapter_test;
    localparam int ADDR_W = 6;
    localparam int BPW    = 4;
    localparam int LW     = 2;
    localparam int IW     = ADDR_W - LW;
    localparam int WW     = 8 * BPW;
    localparam int NWORDS = 1 << IW;
    localparam int NBYTES = 1 << ADDR_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          busy, rsp_valid;
    logic [7:0]    rsp_data;
    logic          mem_req, mem_we;
    logic [IW-1:0] mem_idx;
    logic [WW-1:0] mem_wdata;
    logic [WW-1:0] mem_rdata = '0;

    logic [WW-1:0] store [NWORDS];
    logic [7:0]    shadow [NBYTES];

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    int mem_acc = 0;

    always #2.5 clk = ~clk;

    byte_rmw_adapter #(.ADDR_W(ADDR_W), .BYTES_PER_WORD(BPW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_idx(mem_idx),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Word-only backing store: read data appears the cycle after the strobe.
    always @(posedge clk) begin
        if (mem_req) mem_acc <= mem_acc + 1;
        if (mem_req && mem_we)  store[mem_idx] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= store[mem_idx];
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            misses++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] shadow_word(input int w);
        logic [WW-1:0] r;
        for (int l = 0; l < BPW; l++) r[8*l +: 8] = shadow[w*BPW + l];
        return r;
    endfunction

    // Present one request at a negedge; the accepting edge follows.
    task automatic issue(input bit wr, input int a, input logic [7:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(a);
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_store(input int a, input logic [7:0] d, input bit intrude);
        logic [WW-1:0] exp_w;
        int w;
        w = a >> LW;
        issue(1'b1, a, d);
        // cycle 1: read of the containing word
        chk("R2 read index", mem_idx, w);
        chk("R4 read strobe", {mem_req, mem_we}, 2'b10);
        chk("R5 busy store c1", {busy, req_ready}, 2'b10);
        if (intrude) begin
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = ADDR_W'(a ^ 1); req_wdata = ~d;
        end
        @(negedge clk);
        chk("R8 no access in merge", mem_req, 0);
        chk("R5 busy store c2", busy, 1);
        @(negedge clk);
        req_valid = 1'b0;
        shadow[a] = d;
        exp_w = shadow_word(w);
        chk("R4 write strobe", {mem_req, mem_we}, 2'b11);
        chk("R4 write index", mem_idx, w);
        chk("R4 merged word", mem_wdata, exp_w);
        @(negedge clk);
        chk("R6 no rsp for store", rsp_valid, 0);
        chk("R6 rsp_data zero", rsp_data, 0);
        chk("R5 busy store c4", {busy, req_ready}, 2'b10);
        @(negedge clk);
        chk("R5 ready after store", {busy, req_ready}, 2'b01);
    endtask

    task automatic do_load(input int a);
        issue(1'b0, a, 8'h00);
        chk("R3 read strobe", {mem_req, mem_we}, 2'b10);
        chk("R2 load index", mem_idx, a >> LW);
        chk("R5 busy load c1", {busy, req_ready}, 2'b10);
        @(negedge clk);
        chk("R3 rsp_valid", rsp_valid, 1);
        chk("R3 rsp_data", rsp_data, shadow[a]);
        chk("R8 no access in done", mem_req, 0);
        @(negedge clk);
        chk("R3 rsp one cycle", rsp_valid, 0);
        chk("R5 ready after load", {busy, req_ready}, 2'b01);
    endtask

    initial begin
        int acc0;
        for (int w = 0; w < NWORDS; w++) begin
            for (int l = 0; l < BPW; l++)
                shadow[w*BPW + l] = 8'((w * 37 + l * 11) ^ 8'h5A);
            store[w] = shadow_word(w);
        end
        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset rsp", rsp_valid, 0);
        chk("R1 reset mem_req", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {req_ready, mem_req}, 2'b10);

        // Loads of preset contents: every address, every lane (R2, R3).
        for (int a = 0; a < NBYTES; a++) do_load(a);
        // Stores to every address, then full read-back (R4).
        for (int a = 0; a < NBYTES; a++) do_store(a, 8'(a * 7 + 3), 1'b0);
        for (int a = NBYTES - 1; a >= 0; a--) do_load(a);

        // R7: request held while busy is ignored.
        do_store(9, 8'hC4, 1'b1);
        acc0 = mem_acc;
        repeat (3) @(negedge clk);
        chk("R7 no stray access", mem_acc - acc0, 0);
        do_load(8);
        chk("R7 neighbour kept", shadow[8], 8'(8 * 7 + 3));
        do_load(9);

        // Back-to-back stores to every lane of one word, then read all lanes.
        for (int l = 0; l < BPW; l++) do_store(20 + l, 8'hF0 | 8'(l), 1'b0);
        for (int l = 0; l < BPW; l++) do_load(20 + l);

        summary();
        $finish;
    end
endmodule